// File: doc/BRIEF.md
# Endian-Aware Load Data Formatter

This stage sits between a memory read port and a 64-bit register file whose registers hold packed vector elements. It turns raw memory bytes into a register write value and a byte-enable mask. It applies two byte-order conversions. The first decodes the bytes from memory order into a numeric value. The second lays that value out in the processor's current byte order, at the width of the destination element. No width tag is kept per register. The layout follows only from the element-width mode of the current load and the processor byte-order setting.

There are three element-width modes. The default mode gives a full 64-bit register, extended from a 1, 2, 4 or 8 byte access. The 32-bit element mode writes a single 32-bit element into one half of the register and leaves the other half untouched. The four-element SIMD mode reads 16 bytes and writes two registers on two consecutive beats. The output is registered. A valid/ready handshake carries each beat to the register file.

Top module: `endian_load_formatter`

## Requirements
- R1: After a synchronous active-high reset, `wr_valid` is low and `in_ready` is high.
- R2: In default mode (`ew_mode`=00, and also 11), the access is `acc_size`: 0=1, 1=2, 2=4, 3=8 bytes, taken from `mem_data` byte 0 (bits 7:0, lowest address) upward. When `mem_big` is 1 the lowest-address byte is the most significant, otherwise the least significant.
- R3: In default mode the decoded value is sign-extended to 64 bits when `acc_signed` is 1, and zero-extended otherwise.
- R4: In default mode `wr_be` is 8'hFF. Bits [8k+7:8k] of `wr_data` hold register byte address k. With `cpu_big`=0 the value's least significant byte is at address 0; with `cpu_big`=1 its most significant byte is.
- R5: In 32-bit element mode (`ew_mode`=01), `mem_data` bytes 0..3 are decoded in memory order into a 32-bit value with no extension. `acc_size` and `acc_signed` have no effect.
- R6: In 32-bit element mode the slot is 0 when `dst_vector`=0 and `dst_elem` when `dst_vector`=1. The slot occupies bytes 0..3 (`wr_be`=8'h0F) when slot XOR `cpu_big` is 0, and bytes 4..7 (`wr_be`=8'hF0) otherwise. All other `wr_data` bits are zero.
- R7: Inside the selected slot, the 32-bit value is laid out least significant byte first when `cpu_big`=0, and most significant byte first when `cpu_big`=1.
- R8: In SIMD mode (`ew_mode`=10), element e is decoded from `mem_data` bytes 4e..4e+3. The first beat (`wr_second`=0) carries elements 0 and 1. The next beat (`wr_second`=1) carries elements 2 and 3. Each element of a beat sits in slot 0 or 1, placed per R6 and R7, with `wr_be`=8'hFF.
- R9: A load accepted on a clock edge (`in_valid` and `in_ready`) appears with `wr_valid` high after that edge. Back-to-back single-beat loads are accepted on consecutive cycles while `wr_ready` is high.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_data`, `wr_be` and `wr_second` hold steady and `in_ready` is low.
- R11: While the second SIMD beat is still to be delivered, `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load data available |
| in_ready | output | 1 | Stage can accept a load |
| mem_data | input | 128 | Memory bytes, byte k at bits [8k+7:8k] |
| acc_size | input | 2 | Access size code for default mode |
| acc_signed | input | 1 | Sign-extend in default mode |
| mem_big | input | 1 | Memory byte order is big-endian |
| cpu_big | input | 1 | Processor byte order is big-endian |
| ew_mode | input | 2 | 00 default, 01 32-bit element, 10 SIMD four-element |
| dst_vector | input | 1 | Destination is a vector register |
| dst_elem | input | 1 | Destination element index for vector destinations |
| wr_valid | output | 1 | Register write beat valid |
| wr_ready | input | 1 | Register file takes the beat |
| wr_data | output | 64 | Register write value |
| wr_be | output | 8 | Byte enables, bit k for register byte k |
| wr_second | output | 1 | Beat is the second register of a SIMD load |

## Verification
The hardest case to reach is a SIMD load stalled by `wr_ready`. Here the first beat must stay frozen, the second beat must wait in the holding register, and no new load may slip in. The bench gets there by dropping `wr_ready` before it offers the SIMD load. It then holds each beat for extra cycles and releases them one at a time, checking the outputs and `in_ready` at every step. Every element mode is swept over all four combinations of memory and processor byte order, so that any mix-up between the two swaps shows up.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int REG_BYTES  = 8;
  localparam int ELEM_BYTES = 4;
  localparam int SIMD_ELEMS = 4;
  localparam int REG_W      = 8 * REG_BYTES;
  localparam int ELEM_W     = 8 * ELEM_BYTES;
  localparam int LANES      = REG_BYTES / ELEM_BYTES;
  localparam int SIMD_REGS  = SIMD_ELEMS / LANES;
  localparam int MEM_BYTES  = ELEM_BYTES * SIMD_ELEMS;
  localparam int MEM_W      = 8 * MEM_BYTES;
  localparam int ELEM_IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  typedef enum logic [1:0] {
    EW_DEFAULT = 2'b00,
    EW_ELEM32  = 2'b01,
    EW_SIMD32  = 2'b10,
    EW_RSVD    = 2'b11
  } ew_mode_e;

  typedef struct packed {
    logic [REG_W-1:0]     data;
    logic [REG_BYTES-1:0] be;
  } reg_write_t;

  function automatic int size_bytes(input logic [1:0] sz);
    return 1 << int'(sz);
  endfunction

  // memory bytes -> numeric value, honouring memory byte order
  function automatic logic [REG_W-1:0] decode_mem(input logic [REG_W-1:0] win,
                                                  input int nbytes, input logic big);
    logic [REG_W-1:0] r;
    r = '0;
    for (int k = 0; k < REG_BYTES; k++) begin
      if (k < nbytes) begin
        if (big) r[8*(nbytes-1-k) +: 8] = win[8*k +: 8];
        else     r[8*k +: 8]            = win[8*k +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] extend_val(input logic [REG_W-1:0] v,
                                                  input int nbytes, input logic sgn);
    logic [REG_W-1:0] r;
    logic             fill;
    r    = v;
    fill = sgn & v[8*nbytes-1];
    for (int k = 0; k < REG_BYTES; k++)
      if (k >= nbytes) r[8*k +: 8] = {8{fill}};
    return r;
  endfunction

  function automatic logic [REG_W-1:0] swap_reg(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    for (int k = 0; k < REG_BYTES; k++) r[8*k +: 8] = v[8*(REG_BYTES-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [ELEM_W-1:0] swap_elem(input logic [ELEM_W-1:0] v);
    logic [ELEM_W-1:0] r;
    for (int k = 0; k < ELEM_BYTES; k++) r[8*k +: 8] = v[8*(ELEM_BYTES-1-k) +: 8];
    return r;
  endfunction

  // element slot -> byte lane; big-endian numbers slots from the high address
  function automatic reg_write_t place_elem(input logic [ELEM_W-1:0] v,
                                            input logic [ELEM_IDX_W-1:0] slot,
                                            input logic cpu_big);
    reg_write_t r;
    int         lane;
    r    = '0;
    lane = cpu_big ? (LANES - 1 - int'(slot)) : int'(slot);
    r.data[ELEM_W*lane +: ELEM_W]   = cpu_big ? swap_elem(v) : v;
    r.be[ELEM_BYTES*lane +: ELEM_BYTES] = '1;
    return r;
  endfunction
endpackage

// File: rtl/ldfmt_scalar.sv
module ldfmt_scalar
  import ldfmt_pkg::*;
(
  input  logic [REG_W-1:0] win,
  input  logic [1:0]       size,
  input  logic             sgn,
  input  logic             mem_big,
  input  logic             cpu_big,
  output reg_write_t       wr
);
  int               nbytes;
  logic [REG_W-1:0] raw_val;
  logic [REG_W-1:0] ext_val;
  logic             sign_fill;

  always_comb begin
    nbytes    = size_bytes(size);
    raw_val   = decode_mem(win, nbytes, mem_big);
    ext_val   = extend_val(raw_val, nbytes, sgn);
    sign_fill = sgn & raw_val[8*nbytes-1];
    wr.data   = cpu_big ? swap_reg(ext_val) : ext_val;
    wr.be     = '1;
  end
endmodule

// File: rtl/ldfmt_elem.sv
module ldfmt_elem
  import ldfmt_pkg::*;
(
  input  logic [MEM_W-1:0]      mem_data,
  input  logic                  mem_big,
  input  logic                  cpu_big,
  input  logic [ELEM_IDX_W-1:0] slot,
  output reg_write_t            single,
  output reg_write_t            simd_lo,
  output reg_write_t            simd_hi
);
  logic [ELEM_W-1:0] elem_val [SIMD_ELEMS];
  reg_write_t        simd_reg [SIMD_REGS];

  for (genvar g = 0; g < SIMD_ELEMS; g++) begin : g_dec
    logic [REG_W-1:0] full;
    assign full        = decode_mem({{(REG_W-ELEM_W){1'b0}}, mem_data[ELEM_W*g +: ELEM_W]},
                                    ELEM_BYTES, mem_big);
    assign elem_val[g] = full[ELEM_W-1:0];
  end

  for (genvar r = 0; r < SIMD_REGS; r++) begin : g_reg
    always_comb begin
      reg_write_t part;
      simd_reg[r] = '0;
      for (int l = 0; l < LANES; l++) begin
        part             = place_elem(elem_val[r*LANES+l], ELEM_IDX_W'(l), cpu_big);
        simd_reg[r].data = simd_reg[r].data | part.data;
        simd_reg[r].be   = simd_reg[r].be | part.be;
      end
    end
  end

  assign single  = place_elem(elem_val[0], slot, cpu_big);
  assign simd_lo = simd_reg[0];
  assign simd_hi = simd_reg[1];
endmodule

// File: rtl/ldfmt_beats.sv
module ldfmt_beats
  import ldfmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  reg_write_t           first,
  input  reg_write_t           second,
  input  logic                 two_beats,
  input  logic                 wr_ready,
  output logic                 wr_valid,
  output logic [REG_W-1:0]     wr_data,
  output logic [REG_BYTES-1:0] wr_be,
  output logic                 wr_second
);
  logic       pend_q;
  reg_write_t hold_q;
  logic       accept;
  logic       out_fire;
  logic       beat0_adv;

  assign in_ready  = !rst && !pend_q && (!wr_valid || wr_ready);
  assign accept    = in_valid && in_ready;
  assign out_fire  = wr_valid && wr_ready;
  assign beat0_adv = out_fire && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_second <= 1'b0;
      pend_q    <= 1'b0;
      wr_data   <= '0;
      wr_be     <= '0;
      hold_q    <= '0;
    end else if (accept) begin
      wr_valid  <= 1'b1;
      wr_second <= 1'b0;
      wr_data   <= first.data;
      wr_be     <= first.be;
      pend_q    <= two_beats;
      hold_q    <= second;
    end else if (beat0_adv) begin
      wr_second <= 1'b1;
      wr_data   <= hold_q.data;
      wr_be     <= hold_q.be;
      pend_q    <= 1'b0;
    end else if (out_fire) begin
      wr_valid  <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wr_valid);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> wr_valid && !wr_second);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_be) && $stable(wr_second));
  // R8
  beat_order_chk: assert property (@(posedge clk) disable iff (rst)
    beat0_adv |=> wr_valid && wr_second);
  // R11
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_second && $past(accept) && $past(two_beats) |-> !in_ready || wr_ready);
endmodule

// File: rtl/endian_load_formatter.sv
module endian_load_formatter
  import ldfmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [MEM_W-1:0]      mem_data,
  input  logic [1:0]            acc_size,
  input  logic                  acc_signed,
  input  logic                  mem_big,
  input  logic                  cpu_big,
  input  logic [1:0]            ew_mode,
  input  logic                  dst_vector,
  input  logic [ELEM_IDX_W-1:0] dst_elem,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [REG_W-1:0]      wr_data,
  output logic [REG_BYTES-1:0]  wr_be,
  output logic                  wr_second
);
  localparam logic [REG_BYTES-1:0] BE_LOW  = {{(REG_BYTES-ELEM_BYTES){1'b0}}, {ELEM_BYTES{1'b1}}};
  localparam logic [REG_BYTES-1:0] BE_HIGH = ~BE_LOW;

  ew_mode_e              mode;
  logic [ELEM_IDX_W-1:0] slot;
  reg_write_t            scalar_wr, single_wr, simd_lo, simd_hi;
  reg_write_t            first_wr, second_wr;
  logic                  two_beats;

  assign mode = ew_mode_e'(ew_mode);
  assign slot = dst_vector ? dst_elem : '0;

  ldfmt_scalar u_scalar (
    .win     (mem_data[REG_W-1:0]),
    .size    (acc_size),
    .sgn     (acc_signed),
    .mem_big (mem_big),
    .cpu_big (cpu_big),
    .wr      (scalar_wr)
  );

  ldfmt_elem u_elem (
    .mem_data (mem_data),
    .mem_big  (mem_big),
    .cpu_big  (cpu_big),
    .slot     (slot),
    .single   (single_wr),
    .simd_lo  (simd_lo),
    .simd_hi  (simd_hi)
  );

  always_comb begin
    second_wr = '0;
    two_beats = 1'b0;
    case (mode)
      EW_ELEM32: first_wr = single_wr;
      EW_SIMD32: begin
        first_wr  = simd_lo;
        second_wr = simd_hi;
        two_beats = 1'b1;
      end
      default:   first_wr = scalar_wr;
    endcase
  end

  ldfmt_beats u_beats (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .first     (first_wr),
    .second    (second_wr),
    .two_beats (two_beats),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_second (wr_second)
  );

  // R6
  lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_be == '1) || (wr_be == BE_LOW) || (wr_be == BE_HIGH));
  // R6
  lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && (wr_be == BE_LOW) |-> wr_data[REG_W-1:ELEM_W] == '0);
  // R4
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (mode == EW_DEFAULT) |=> wr_be == '1);
endmodule

// File: tb/tb_endian_load_formatter.sv
`timescale 1ns/1ps
module tb_endian_load_formatter;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] mem_data;
  logic [1:0]   acc_size;
  logic         acc_signed, mem_big, cpu_big;
  logic [1:0]   ew_mode;
  logic         dst_vector;
  logic [0:0]   dst_elem;
  logic         wr_valid, wr_ready;
  logic [63:0]  wr_data;
  logic [7:0]   wr_be;
  logic         wr_second;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  endian_load_formatter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mem_data(mem_data), .acc_size(acc_size), .acc_signed(acc_signed),
    .mem_big(mem_big), .cpu_big(cpu_big), .ew_mode(ew_mode),
    .dst_vector(dst_vector), .dst_elem(dst_elem), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be), .wr_second(wr_second)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [127:0] m, input int e, input logic mb);
    logic [7:0] b0, b1, b2, b3;
    b0 = m[32*e +: 8]; b1 = m[32*e+8 +: 8]; b2 = m[32*e+16 +: 8]; b3 = m[32*e+24 +: 8];
    return mb ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  // returns {data, be}
  function automatic logic [71:0] model(input logic [127:0] m, input logic [1:0] sz,
      input logic sg, input logic mb, input logic cb, input logic [1:0] md,
      input logic vec, input logic idx, input logic beat);
    logic [7:0]  rb [8];
    logic [7:0]  be;
    logic [63:0] v, d;
    logic [31:0] w;
    int n, lane;
    for (int k = 0; k < 8; k++) rb[k] = 8'h00;
    if (md == 2'b01) begin
      w    = word_of(m, 0, mb);
      lane = int'((vec ? idx : 1'b0) ^ cb);
      for (int j = 0; j < 4; j++) rb[4*lane+j] = cb ? w[8*(3-j) +: 8] : w[8*j +: 8];
      be = (lane == 1) ? 8'hF0 : 8'h0F;
    end else if (md == 2'b10) begin
      for (int l = 0; l < 2; l++) begin
        w    = word_of(m, 2*int'(beat) + l, mb);
        lane = l ^ int'(cb);
        for (int j = 0; j < 4; j++) rb[4*lane+j] = cb ? w[8*(3-j) +: 8] : w[8*j +: 8];
      end
      be = 8'hFF;
    end else begin
      n = 1 << sz;
      v = '0;
      for (int i = 0; i < n; i++) v[8*(mb ? n-1-i : i) +: 8] = m[8*i +: 8];
      if (sg && v[8*n-1]) for (int i = n; i < 8; i++) v[8*i +: 8] = 8'hFF;
      for (int k = 0; k < 8; k++) rb[k] = cb ? v[8*(7-k) +: 8] : v[8*k +: 8];
      be = 8'hFF;
    end
    for (int k = 0; k < 8; k++) d[8*k +: 8] = rb[k];
    return {d, be};
  endfunction

  task automatic drive(input logic [127:0] m, input logic [1:0] sz, input logic sg,
      input logic mb, input logic cb, input logic [1:0] md, input logic vec, input logic idx);
    mem_data = m; acc_size = sz; acc_signed = sg; mem_big = mb; cpu_big = cb;
    ew_mode = md; dst_vector = vec; dst_elem = idx; in_valid = 1'b1;
  endtask

  task automatic expect_beat(input string req, input logic [127:0] m, input logic [1:0] sz,
      input logic sg, input logic mb, input logic cb, input logic [1:0] md,
      input logic vec, input logic idx, input logic beat);
    logic [71:0] e;
    e = model(m, sz, sg, mb, cb, md, vec, idx, beat);
    chk({req, " valid"}, {63'b0, wr_valid}, 64'd1);
    chk({req, " data"}, wr_data, e[71:8]);
    chk({req, " be"}, {56'b0, wr_be}, {56'b0, e[7:0]});
    chk({req, " second"}, {63'b0, wr_second}, {63'b0, beat});
  endtask

  // one load with wr_ready high: drive at negedge, accepted at posedge, check next negedge
  task automatic run_op(input string req, input logic [127:0] m, input logic [1:0] sz,
      input logic sg, input logic mb, input logic cb, input logic [1:0] md,
      input logic vec, input logic idx);
    @(negedge clk);
    drive(m, sz, sg, mb, cb, md, vec, idx);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat(req, m, sz, sg, mb, cb, md, vec, idx, 1'b0);
    if (md == 2'b10) begin
      @(negedge clk);
      expect_beat(req, m, sz, sg, mb, cb, md, vec, idx, 1'b1);
    end
  endtask

  localparam logic [127:0] PAT_A = 128'h100f0e0d_0c0b0a09_08070605_04030201;
  localparam logic [127:0] PAT_B = 128'h3c5a7e91_a2b3c4d5_e6f70819_2a3b4c8d;
  localparam logic [127:0] PAT_C = 128'h1122_3344_5566_7788_f1e2_d3c4_b5a6_9788;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 wr_valid after reset", {63'b0, wr_valid}, 64'd0);
    chk("R1 in_ready after reset", {63'b0, in_ready}, 64'd1);
  endtask

  task automatic t_hand();
    // word at bytes 0..3 is 0x04030201 under little-endian memory order
    run_op("R4 hand LE", PAT_A, 2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    chk("R4 hand LE value", wr_data, 64'h0000_0000_0403_0201);
    run_op("R4 hand BE", PAT_A, 2'd2, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    chk("R4 hand BE value", wr_data, 64'h0102_0304_0000_0000);
    run_op("R6 hand", PAT_A, 2'd0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
    chk("R7 hand slot value", wr_data, 64'h0102_0304_0000_0000);
    chk("R6 hand slot mask", {56'b0, wr_be}, 64'h0000_0000_0000_00F0);
  endtask

  task automatic t_default();
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 8; o++)
          run_op("R2 R3 R4 default", (p == 0) ? PAT_B : PAT_C, 2'(s), o[0], o[1], o[2],
                 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_elem32();
    for (int o = 0; o < 16; o++)
      run_op("R5 R6 R7 elem32", PAT_B, 2'(o), 1'b1, o[0], o[1], 2'b01, o[2], o[3]);
    for (int o = 0; o < 4; o++)
      run_op("R5 size ignored", PAT_C, 2'(3 - o), o[0], o[1], o[0], 2'b01, 1'b1, 1'b1);
  endtask

  task automatic t_simd();
    for (int o = 0; o < 4; o++)
      run_op("R8 simd", PAT_C, 2'd0, 1'b0, o[0], o[1], 2'b10, 1'b0, 1'b0);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    drive(PAT_B, 2'd3, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    expect_beat("R9 first", PAT_B, 2'd3, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R9 ready back-to-back", {63'b0, in_ready}, 64'd1);
    drive(PAT_C, 2'd1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat("R9 second", PAT_C, 2'd1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    wr_ready = 1'b0;
    drive(PAT_B, 2'd0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    expect_beat("R10 stall beat0", PAT_B, 2'd0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    chk("R11 ready low pending", {63'b0, in_ready}, 64'd0);
    @(negedge clk);
    expect_beat("R10 held beat0", PAT_B, 2'd0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    chk("R11 ready still low", {63'b0, in_ready}, 64'd0);
    wr_ready = 1'b1;
    @(negedge clk);
    expect_beat("R8 stall beat1", PAT_B, 2'd0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1);
    wr_ready = 1'b0;
    @(negedge clk);
    expect_beat("R10 held beat1", PAT_B, 2'd0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1);
    chk("R10 ready low stalled", {63'b0, in_ready}, 64'd0);
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained valid", {63'b0, wr_valid}, 64'd0);
    chk("R10 drained ready", {63'b0, in_ready}, 64'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; wr_ready = 1'b1;
    mem_data = '0; acc_size = '0; acc_signed = 1'b0; mem_big = 1'b0; cpu_big = 1'b0;
    ew_mode = 2'b00; dst_vector = 1'b0; dst_elem = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hand();
    t_default();
    t_elem32();
    t_simd();
    t_b2b();
    t_stall();
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule